// File: doc/BRIEF.md
# LCD Frame and Boost Clock Divider

This block turns the ticks of the internal oscillator of a multiplexed character LCD controller into the timing that the display drive and the charge pump need. A digit divider counts oscillator ticks and wraps once every `DIGITS` ticks. Each wrap emits a one-cycle strobe that moves the active common line forward. A line divider counts those strobes and flips a frame signal each time all `DUTY` common lines have been scanned. Because the oscillator runs at digits × duty × frame rate, this gives one frame toggle per display frame. A nominal 100 Hz frame lies within a usable 70–130 Hz band.

The charge-pump clock runs at the oscillator rate divided by twice the digit count. It flips on every digit wrap, so one full period spans `2 × DIGITS` ticks. With 13 digits and a 30-line duty, a 39 kHz oscillator gives a 100 Hz frame and a boost clock of about 1.5 kHz. The oscillator is modelled as a tick enable (`osc_tick`) in the system clock domain. The oscillation control (`osc_en`) stops the chain in sleep mode: while it is low, every counter sits at zero and every output is low. In standby the oscillation control stays high and the chain keeps running.

Top module: `lcd_timing_gen`

## Requirements
- R1: While `rst_n` is low, `com_step`, `frame_tgl` and `boost_clk` are low.
- R2: With `osc_en` high, `com_step` is high for exactly one clock cycle, in the cycle after every `DIGITS`-th accepted tick (the 1st, 2nd, ... multiple of `DIGITS` counted from reset or re-enable), and low otherwise.
- R3: A clock cycle with `osc_tick` low advances no counter. It produces no `com_step` and changes neither `frame_tgl` nor `boost_clk`.
- R4: `frame_tgl` starts low after enable and inverts once every `DIGITS × DUTY` accepted ticks, in the same cycle as the `com_step` that completes the last common line.
- R5: `boost_clk` starts low after enable and inverts once every `DIGITS` accepted ticks, giving a period of `2 × DIGITS` ticks.
- R6: One clock edge after `osc_en` is sampled low, all three outputs are low and all counters are at zero. After re-enable, counting restarts from zero.
- R7: `osc_tick` pulses while `osc_en` is low have no effect: the outputs stay low, and the first `com_step` after re-enable still needs `DIGITS` ticks.
- R8: While enabled, `frame_tgl` and `boost_clk` change only in a cycle where `com_step` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| osc_en | input | 1 | Oscillation control; low stops and clears the chain |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| com_step | output | 1 | One-cycle strobe that advances the common line |
| frame_tgl | output | 1 | Level that inverts once per frame |
| boost_clk | output | 1 | Charge-pump clock, period 2 × DIGITS ticks |

## Verification
The assertions assume that `osc_tick` is a single-cycle pulse in the system clock domain and that it can come on any cycle, including back to back. They also assume that `osc_en` is synchronous, so that dropping it is seen on one clock edge. The stimulus keeps to these rules: it drives both inputs between edges and uses four tick patterns (continuous, every third cycle, pseudo-random, and ticks while disabled) with periodic sleep intervals. A small configuration lets every counter value and every wrap be visited many times.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
    // Width of a counter holding 0..n-1, at least one bit.
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/lcdt_digit_div.sv
module lcdt_digit_div #(
    parameter int DIGITS = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    output logic wrap_o,
    output logic step_o
);
    localparam int DW = lcdt_pkg::cnt_width(DIGITS);
    localparam logic [DW-1:0] LAST = DW'(DIGITS - 1);

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          step;
    } dig_st_t;

    dig_st_t s_d, s_q;
    logic    at_end;

    assign at_end = (s_q.cnt == LAST);
    assign wrap_o = run_i && tick_i && at_end;
    assign step_o = s_q.step;

    always_comb begin
        s_d      = s_q;
        s_d.step = 1'b0;
        if (!run_i) begin
            s_d = '0;
        end else if (tick_i) begin
            s_d.cnt  = at_end ? '0 : s_q.cnt + 1'b1;
            s_d.step = at_end;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R2: the last digit plus a tick yields a strobe next cycle
    a_r2_step_after_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && at_end) |=> step_o);
    // R3: no tick, no advance
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick_i) |=> ($stable(s_q.cnt) && !step_o));
    // R6: disabled clears the counter
    a_r6_digit_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (s_q.cnt == '0 && !step_o));
endmodule

// File: rtl/lcdt_line_div.sv
module lcdt_line_div #(
    parameter int DUTY = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic adv_i,
    output logic frame_o
);
    localparam int LW = lcdt_pkg::cnt_width(DUTY);
    localparam logic [LW-1:0] LAST = LW'(DUTY - 1);

    typedef struct packed {
        logic [LW-1:0] line;
        logic          frame;
    } line_st_t;

    line_st_t s_d, s_q;
    logic     at_end;

    assign at_end  = (s_q.line == LAST);
    assign frame_o = s_q.frame;

    always_comb begin
        s_d = s_q;
        if (!run_i) begin
            s_d = '0;
        end else if (adv_i) begin
            s_d.line  = at_end ? '0 : s_q.line + 1'b1;
            s_d.frame = s_q.frame ^ at_end;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4: frame inverts when the last line is advanced
    a_r4_frame_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && adv_i && at_end) |=> (frame_o != $past(frame_o)));
    // R4: frame holds between line wraps
    a_r4_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !(adv_i && at_end)) |=> $stable(frame_o));
    // R6: disabled clears the line counter and frame
    a_r6_line_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (s_q.line == '0 && !frame_o));
endmodule

// File: rtl/lcdt_boost_div.sv
module lcdt_boost_div (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic adv_i,
    output logic boost_o
);
    typedef struct packed {
        logic level;
    } bst_st_t;

    bst_st_t s_d, s_q;

    assign boost_o = s_q.level;

    always_comb begin
        s_d = s_q;
        if (!run_i)     s_d.level = 1'b0;
        else if (adv_i) s_d.level = ~s_q.level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R5: each digit wrap inverts the boost clock
    a_r5_boost_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && adv_i) |=> (boost_o != $past(boost_o)));
    // R6: disabled forces the boost clock low
    a_r6_boost_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !boost_o);
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen #(
    parameter int DIGITS = 13,
    parameter int DUTY   = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_en,
    input  logic osc_tick,
    output logic com_step,
    output logic frame_tgl,
    output logic boost_clk
);
    logic digit_wrap;

    lcdt_digit_div #(.DIGITS(DIGITS)) u_digit (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (osc_en),
        .tick_i (osc_tick),
        .wrap_o (digit_wrap),
        .step_o (com_step)
    );

    lcdt_line_div #(.DUTY(DUTY)) u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (osc_en),
        .adv_i   (digit_wrap),
        .frame_o (frame_tgl)
    );

    lcdt_boost_div u_boost (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (osc_en),
        .adv_i   (digit_wrap),
        .boost_o (boost_clk)
    );

    // R1: outputs low during reset
    always_comb begin
        if (!rst_n) begin
            a_r1_reset_low: assert (!com_step && !frame_tgl && !boost_clk);
        end
    end

    // R8: while enabled, frame and boost move only with a line strobe
    a_r8_frame_with_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(osc_en) && frame_tgl != $past(frame_tgl)) |-> com_step);
    a_r8_boost_with_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(osc_en) && boost_clk != $past(boost_clk)) |-> com_step);
endmodule

// File: tb/lcd_timing_gen_tb_top.sv
module lcd_timing_gen_tb_top;
    localparam int D = 3;
    localparam int L = 5;
    localparam time CP = 8ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_en = 1'b0;
    logic osc_tick = 1'b0;
    logic com_step, frame_tgl, boost_clk;

    int total = 0;
    int bad = 0;
    int n = 0;
    logic [7:0] lfsr = 8'hA5;

    always #(CP/2) clk = ~clk;

    lcd_timing_gen #(.DIGITS(D), .DUTY(L)) dut_i (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .osc_tick(osc_tick),
        .com_step(com_step), .frame_tgl(frame_tgl), .boost_clk(boost_clk)
    );

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
        end
    endtask

    // one cycle: apply inputs, take the edge, compare with the arithmetic model
    task automatic cyc(input logic e, input logic t);
        logic ticked;
        osc_en = e;
        osc_tick = t;
        @(posedge clk);
        #1;
        ticked = e && t;
        if (!e) n = 0;
        else if (t) n++;
        if (!e) begin
            check("R6 step", com_step, 1'b0);
            check("R6 frame", frame_tgl, 1'b0);
            check("R7 boost", boost_clk, 1'b0);
        end else begin
            check(t ? "R2 step" : "R3 step", com_step, ticked && (n % D == 0));
            check("R4 frame", frame_tgl, 1'((n / (D * L)) % 2));
            check("R5 boost", boost_clk, 1'((n / D) % 2));
        end
    endtask

    initial begin
        #(CP * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CP * 3);
        check("R1 step", com_step, 1'b0);
        check("R1 frame", frame_tgl, 1'b0);
        check("R1 boost", boost_clk, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // continuous ticks
        for (int i = 0; i < 200; i++) cyc(1'b1, 1'b1);
        // every third cycle (R3 gaps)
        for (int i = 0; i < 300; i++) cyc(1'b1, (i % 3) == 0);
        // sleep with ticks still arriving (R7), then restart (R6)
        for (int i = 0; i < 20; i++) cyc(1'b0, 1'b1);
        for (int i = 0; i < 2 * D; i++) cyc(1'b1, 1'b1);
        // pseudo-random ticks with periodic sleep
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            cyc((i % 211) > 7, lfsr[0]);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule